// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a processor core that runs in several privilege modes. Software sees sixteen 32-bit general registers, but some of them are backed by private copies that belong to one mode. When the mode changes, the block swaps those copies in and out of view. It also holds the current status word and one saved-status register for each exception mode. A mode-change request carries a 5-bit mode code. The two read ports and the single write port take a logical register number from 0 to 15. The block maps that number to the physical copy that the current mode selects.

The fast-interrupt mode has its own copies of registers 8 to 14. The interrupt, supervisor, abort and undefined modes each have private copies of registers 13 and 14 only. User and system modes share one pair, which no other mode can see. Register 15 is a single register. All control and data pins are plain, level-sampled signals with no back-pressure: every request present at a rising edge is taken in that cycle, and the reads are combinational. Decode, exception sequencing and arithmetic sit outside this block.

Top module: `bank_regfile`

## Requirements
- R1: After reset the mode is supervisor (0x13) and the status word is 0x000000D3, with interrupt-disable bits 7 and 6 set and the mode in bits 4:0. Supervisor register 13 reads 0x10000000. Register 15, every other register copy and every saved-status register read 0.
- R2: A request with one of the legal codes switches the mode at the next rising edge. The legal codes are user 0x10, fast-interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. After the switch, mode_o and status bits 4:0 show the new code.
- R3: A request carrying any other code is ignored. The mode, the status word and the registers in view stay as they were.
- R4: A request naming the mode that is already active has no effect.
- R5: User and system modes share one copy of registers 13 and 14. A value written in either mode can be read in the other.
- R6: The interrupt, supervisor, abort and undefined modes each keep private copies of registers 13 and 14. Registers 0 to 12 are shared by all modes except fast-interrupt.
- R7: Fast-interrupt mode has private copies of registers 8 to 14. Registers 0 to 7 and register 15 are the same physical registers in every mode.
- R8: Each exception mode has its own saved-status register. The saved-status port reads and writes the copy that belongs to the current mode.
- R9: In user and system modes the saved-status port reads 0, and a write to it is ignored.
- R10: A status write replaces bits 31:5 and leaves the mode field alone. A mode switch replaces only bits 4:0.
- R11: Both read ports return the selected register in the same cycle. A write becomes visible after the next rising edge.
- R12: When a register write or saved-status write comes in the same cycle as a mode change, the write goes to the copy of the old mode, and then the mode switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req_valid | input | 1 | Mode-change request strobe |
| mode_req_code | input | 5 | Requested mode code |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Logical register number to write |
| wr_data | input | 32 | Register write data |
| rd_a_idx | input | 4 | Read port A logical register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B logical register number |
| rd_b_data | output | 32 | Read port B data |
| stat_wr_en | input | 1 | Status word write enable (bits 31:5) |
| stat_wr_data | input | 32 | Status word write data |
| sav_wr_en | input | 1 | Saved-status write enable |
| sav_wr_data | input | 32 | Saved-status write data |
| sav_rd_data | output | 32 | Saved-status register of the current mode |
| mode_o | output | 5 | Current mode code |
| status_o | output | 32 | Current status word |

## Verification
The assertions assume that reset is held across at least one rising edge. They also assume the control pins carry no unknown values while reset is released. The mode code on a request may be any 5-bit value: the checker decides for itself which codes are legal, so bad codes are allowed and are covered by the checks. The bench drives every input at the falling edge and reads only after it has settled. Each input therefore stays stable around the rising edge that the checker samples.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int MODE_W = 5;
  localparam int IDX_W  = 4;

  // physical copies: 8 low shared, 5 normal high, 5 fiq high, 1 pc, 6 pairs sp/lr
  localparam int NBANKS   = 6;
  localparam int P_FIQHI  = 13;
  localparam int P_PC     = 18;
  localparam int P_SPLR   = 19;
  localparam int NPHYS    = P_SPLR + 2 * NBANKS;
  localparam int PHYS_W   = $clog2(NPHYS);
  localparam int NSAVED   = NBANKS - 1;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam logic [MODE_W-1:0] M_USR = 5'h10;
  localparam logic [MODE_W-1:0] M_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] M_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] M_SVC = 5'h13;
  localparam logic [MODE_W-1:0] M_ABT = 5'h17;
  localparam logic [MODE_W-1:0] M_UND = 5'h1B;
  localparam logic [MODE_W-1:0] M_SYS = 5'h1F;
endpackage

// File: rtl/bank_mode_decode.sv
module bank_mode_decode
  import bank_pkg::*;
(
  input  logic [MODE_W-1:0] code,
  output logic              legal,
  output bank_e             bank
);
  always_comb begin
    legal = 1'b1;
    bank  = BK_USR;
    case (code)
      M_USR, M_SYS: bank = BK_USR;
      M_FIQ:        bank = BK_FIQ;
      M_IRQ:        bank = BK_IRQ;
      M_SVC:        bank = BK_SVC;
      M_ABT:        bank = BK_ABT;
      M_UND:        bank = BK_UND;
      default:      legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/bank_index_map.sv
module bank_index_map
  import bank_pkg::*;
(
  input  bank_e             bank,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] pidx
);
  logic [PHYS_W-1:0] ext;

  always_comb begin
    ext = PHYS_W'(idx);
    if (idx < IDX_W'(8))
      pidx = ext;
    else if (idx == IDX_W'(15))
      pidx = PHYS_W'(P_PC);
    else if (idx >= IDX_W'(13))
      pidx = PHYS_W'(P_SPLR) + PHYS_W'({bank, 1'b0}) + (ext - PHYS_W'(13));
    else if (bank == BK_FIQ)
      pidx = PHYS_W'(P_FIQHI) + (ext - PHYS_W'(8));
    else
      pidx = ext;
  end
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter logic [DATA_W-1:0] RESET_SP = 32'h1000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_req_valid,
  input  logic [MODE_W-1:0] mode_req_code,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              stat_wr_en,
  input  logic [DATA_W-1:0] stat_wr_data,
  input  logic              sav_wr_en,
  input  logic [DATA_W-1:0] sav_wr_data,
  output logic [DATA_W-1:0] sav_rd_data,
  output logic [MODE_W-1:0] mode_o,
  output logic [DATA_W-1:0] status_o
);
  localparam int                NUM_RD      = 2;
  localparam int                SVC_SP      = P_SPLR + 2 * int'(BK_SVC);
  localparam logic [DATA_W-1:0] RESET_FLAGS = DATA_W'(32'h0000_00C0);

  logic [DATA_W-1:0]      phys_q  [NPHYS];
  logic [DATA_W-1:0]      saved_q [NSAVED];
  logic [MODE_W-1:0]      mode_q;
  bank_e                  bank_q;
  logic [DATA_W-1:MODE_W] flags_q;

  // mode request decode
  logic  req_legal;
  bank_e req_bank;
  logic  do_switch;

  bank_mode_decode u_dec (
    .code  (mode_req_code),
    .legal (req_legal),
    .bank  (req_bank)
  );

  assign do_switch = mode_req_valid && req_legal && (mode_req_code != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_SVC;
      bank_q  <= BK_SVC;
      flags_q <= RESET_FLAGS[DATA_W-1:MODE_W];
    end else begin
      if (do_switch) begin
        mode_q <= mode_req_code;
        bank_q <= req_bank;
      end
      if (stat_wr_en) flags_q <= stat_wr_data[DATA_W-1:MODE_W];
    end
  end

  assign mode_o   = mode_q;
  assign status_o = {flags_q, mode_q};

  // read ports: logical to physical through the current bank
  logic [IDX_W-1:0]  rd_idx  [NUM_RD];
  logic [PHYS_W-1:0] rd_pidx [NUM_RD];
  logic [DATA_W-1:0] rd_data [NUM_RD];

  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    bank_index_map u_map (
      .bank (bank_q),
      .idx  (rd_idx[r]),
      .pidx (rd_pidx[r])
    );
    assign rd_data[r] = phys_q[rd_pidx[r]];
  end

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];

  // write port uses the bank held before any switch in this cycle
  logic [PHYS_W-1:0] wr_pidx;

  bank_index_map u_wmap (
    .bank (bank_q),
    .idx  (wr_idx),
    .pidx (wr_pidx)
  );

  for (genvar p = 0; p < NPHYS; p++) begin : g_phys
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        phys_q[p] <= (p == SVC_SP) ? RESET_SP : '0;
      else if (wr_en && wr_pidx == PHYS_W'(p))
        phys_q[p] <= wr_data;
    end
  end

  // saved-status copies, one per exception bank
  logic [2:0] sav_sel;
  logic       sav_present;

  assign sav_present = (bank_q != BK_USR);
  assign sav_sel     = 3'(bank_q) - 3'd1;

  for (genvar s = 0; s < NSAVED; s++) begin : g_sav
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        saved_q[s] <= '0;
      else if (sav_wr_en && sav_present && sav_sel == 3'(s))
        saved_q[s] <= sav_wr_data;
    end
  end

  assign sav_rd_data = sav_present ? saved_q[sav_sel] : '0;
endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_req_valid,
  input logic [4:0]  mode_req_code,
  input logic        wr_en,
  input logic [3:0]  wr_idx,
  input logic [31:0] wr_data,
  input logic [3:0]  rd_a_idx,
  input logic [31:0] rd_a_data,
  input logic        stat_wr_en,
  input logic [31:0] sav_rd_data,
  input logic [4:0]  mode_o,
  input logic [31:0] status_o
);
  logic code_ok;
  assign code_ok = (mode_req_code == 5'h10) || (mode_req_code == 5'h11) ||
                   (mode_req_code == 5'h12) || (mode_req_code == 5'h13) ||
                   (mode_req_code == 5'h17) || (mode_req_code == 5'h1B) ||
                   (mode_req_code == 5'h1F);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (mode_o == 5'h13) && (status_o[7:6] == 2'b11));

  // R2
  legal_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req_valid && code_ok) |=> (mode_o == $past(mode_req_code)) &&
                                   (status_o[4:0] == $past(mode_req_code)));

  // R3
  bad_code_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req_valid && !code_ok) |=> $stable(mode_o));

  // R9
  no_saved_in_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 5'h10) || (mode_o == 5'h1F)) |-> (sav_rd_data == 32'h0));

  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr_en |=> $stable(status_o[31:5]));

  // R11
  pc_write_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd15) |=> (rd_a_idx != 4'd15) || (rd_a_data == $past(wr_data)));
endmodule

bind bank_regfile bank_regfile_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mode_req_valid (mode_req_valid),
  .mode_req_code  (mode_req_code),
  .wr_en          (wr_en),
  .wr_idx         (wr_idx),
  .wr_data        (wr_data),
  .rd_a_idx       (rd_a_idx),
  .rd_a_data      (rd_a_data),
  .stat_wr_en     (stat_wr_en),
  .sav_rd_data    (sav_rd_data),
  .mode_o         (mode_o),
  .status_o       (status_o)
);

// File: tb/bank_regfile_test.sv
`timescale 1ns/1ps
module bank_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_req_valid = 1'b0;
  logic [4:0]  mode_req_code = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_a_idx = '0;
  logic [31:0] rd_a_data;
  logic [3:0]  rd_b_idx = '0;
  logic [31:0] rd_b_data;
  logic        stat_wr_en = 1'b0;
  logic [31:0] stat_wr_data = '0;
  logic        sav_wr_en = 1'b0;
  logic [31:0] sav_wr_data = '0;
  logic [31:0] sav_rd_data;
  logic [4:0]  mode_o;
  logic [31:0] status_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bank_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .mode_req_valid(mode_req_valid), .mode_req_code(mode_req_code),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
    .sav_wr_en(sav_wr_en), .sav_wr_data(sav_wr_data), .sav_rd_data(sav_rd_data),
    .mode_o(mode_o), .status_o(status_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  // one clock of stimulus, applied at the falling edge and cleared after the rising edge
  task automatic cyc(input logic we, input logic [3:0] wi, input logic [31:0] wd,
                     input logic mv, input logic [4:0] mc,
                     input logic sw, input logic [31:0] sd,
                     input logic tw, input logic [31:0] td);
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd;
    mode_req_valid = mv; mode_req_code = mc;
    sav_wr_en = sw; sav_wr_data = sd;
    stat_wr_en = tw; stat_wr_data = td;
    @(negedge clk);
    wr_en = 1'b0; mode_req_valid = 1'b0; sav_wr_en = 1'b0; stat_wr_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] i, input logic [31:0] d);
    cyc(1'b1, i, d, 1'b0, 5'h0, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic setmode(input logic [4:0] m);
    cyc(1'b0, 4'h0, 32'h0, 1'b1, m, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic savwr(input logic [31:0] d);
    cyc(1'b0, 4'h0, 32'h0, 1'b0, 5'h0, 1'b1, d, 1'b0, 32'h0);
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] i, input logic [31:0] exp);
    rd_a_idx = i; rd_b_idx = i;
    #1;
    chk({tag, " portA"}, rd_a_data, exp);
    chk({tag, " portB"}, rd_b_data, exp);
  endtask

  task automatic t_reset();
    chk("R1 mode", 32'(mode_o), 32'h13);
    chk("R1 status", status_o, 32'h0000_00D3);
    rd_chk("R1 svc sp", 4'd13, 32'h1000_0000);
    rd_chk("R1 pc", 4'd15, 32'h0);
    rd_chk("R1 r14", 4'd14, 32'h0);
    chk("R1 saved", sav_rd_data, 32'h0);
  endtask

  task automatic t_rw();
    wr(4'd0, 32'hA5A5_0000);
    wr(4'd12, 32'h0C0C_0C0C);
    rd_a_idx = 4'd0; rd_b_idx = 4'd12;
    #1;
    chk("R11 dual read A", rd_a_data, 32'hA5A5_0000);
    chk("R11 dual read B", rd_b_data, 32'h0C0C_0C0C);
  endtask

  task automatic t_modes();
    logic [4:0] codes [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
    for (int k = 0; k < 7; k++) begin
      setmode(codes[k]);
      chk("R2 mode", 32'(mode_o), 32'(codes[k]));
      chk("R2 status field", 32'(status_o[4:0]), 32'(codes[k]));
    end
  endtask

  task automatic t_exc_banks();
    logic [4:0] codes [4] = '{5'h12, 5'h13, 5'h17, 5'h1B};
    setmode(5'h10);
    wr(4'd5, 32'h5555_0005);
    for (int k = 0; k < 4; k++) begin
      setmode(codes[k]);
      wr(4'd13, 32'h1300_0000 | 32'(codes[k]));
      wr(4'd14, 32'h1400_0000 | 32'(codes[k]));
    end
    for (int k = 0; k < 4; k++) begin
      setmode(codes[k]);
      rd_chk("R6 private r13", 4'd13, 32'h1300_0000 | 32'(codes[k]));
      rd_chk("R6 private r14", 4'd14, 32'h1400_0000 | 32'(codes[k]));
      rd_chk("R6 shared r5", 4'd5, 32'h5555_0005);
      rd_chk("R6 shared r12", 4'd12, 32'h0C0C_0C0C);
    end
  endtask

  task automatic t_fiq();
    setmode(5'h10);
    for (int i = 8; i <= 14; i++) wr(4'(i), 32'h0800_0000 + 32'(i));
    wr(4'd15, 32'h0000_0F15);
    wr(4'd3, 32'h0333_0333);
    setmode(5'h11);
    for (int i = 8; i <= 14; i++) rd_chk("R7 fiq fresh", 4'(i), 32'h0);
    for (int i = 8; i <= 14; i++) wr(4'(i), 32'h0F00_0000 + 32'(i));
    for (int i = 8; i <= 14; i++) rd_chk("R7 fiq own", 4'(i), 32'h0F00_0000 + 32'(i));
    rd_chk("R7 shared r3", 4'd3, 32'h0333_0333);
    rd_chk("R7 pc unbanked", 4'd15, 32'h0000_0F15);
    setmode(5'h10);
    for (int i = 8; i <= 14; i++) rd_chk("R7 user kept", 4'(i), 32'h0800_0000 + 32'(i));
    setmode(5'h12);
    rd_chk("R7 irq sees user r8", 4'd8, 32'h0800_0008);
  endtask

  task automatic t_usr_sys();
    setmode(5'h10);
    wr(4'd13, 32'h0000_ABCD);
    setmode(5'h1F);
    rd_chk("R5 sys sees user r13", 4'd13, 32'h0000_ABCD);
    wr(4'd14, 32'h0000_0077);
    setmode(5'h10);
    rd_chk("R5 user sees sys r14", 4'd14, 32'h0000_0077);
    setmode(5'h12);
    rd_chk("R5 irq r14 separate", 4'd14, 32'h1400_0012);
  endtask

  task automatic t_saved();
    setmode(5'h12);
    savwr(32'h1234_5670);
    setmode(5'h13);
    savwr(32'hAAAA_0000);
    chk("R8 svc saved", sav_rd_data, 32'hAAAA_0000);
    setmode(5'h12);
    chk("R8 irq saved", sav_rd_data, 32'h1234_5670);
    setmode(5'h11);
    chk("R8 fiq saved untouched", sav_rd_data, 32'h0);
    setmode(5'h10);
    savwr(32'h0000_FFFF);
    chk("R9 user saved reads zero", sav_rd_data, 32'h0);
    setmode(5'h1F);
    savwr(32'h0000_EEEE);
    chk("R9 sys saved reads zero", sav_rd_data, 32'h0);
    setmode(5'h12);
    chk("R9 irq saved unaffected", sav_rd_data, 32'h1234_5670);
    setmode(5'h13);
    chk("R9 svc saved unaffected", sav_rd_data, 32'hAAAA_0000);
  endtask

  task automatic t_status();
    setmode(5'h13);
    cyc(1'b0, 4'h0, 32'h0, 1'b0, 5'h0, 1'b0, 32'h0, 1'b1, 32'hF000_00FF);
    chk("R10 status write", status_o, 32'hF000_00F3);
    setmode(5'h17);
    chk("R10 switch keeps flags", status_o, 32'hF000_00F7);
  endtask

  task automatic t_invalid();
    logic [4:0] bad [3] = '{5'h00, 5'h15, 5'h1A};
    setmode(5'h12);
    for (int k = 0; k < 3; k++) begin
      setmode(bad[k]);
      chk("R3 mode kept", 32'(mode_o), 32'h12);
      chk("R3 status kept", status_o, 32'hF000_00F2);
      rd_chk("R3 view kept", 4'd13, 32'h1300_0012);
    end
  endtask

  task automatic t_same();
    setmode(5'h17);
    setmode(5'h17);
    chk("R4 mode", 32'(mode_o), 32'h17);
    chk("R4 status", status_o, 32'hF000_00F7);
    rd_chk("R4 view", 4'd13, 32'h1300_0017);
  endtask

  task automatic t_order();
    setmode(5'h12);
    wr(4'd13, 32'h0000_4242);
    savwr(32'h0000_4343);
    setmode(5'h13);
    cyc(1'b1, 4'd13, 32'h0000_9999, 1'b1, 5'h12, 1'b1, 32'h0000_5151, 1'b0, 32'h0);
    chk("R12 mode switched", 32'(mode_o), 32'h12);
    rd_chk("R12 irq r13 untouched", 4'd13, 32'h0000_4242);
    chk("R12 irq saved untouched", sav_rd_data, 32'h0000_4343);
    setmode(5'h13);
    rd_chk("R12 svc r13 got write", 4'd13, 32'h0000_9999);
    chk("R12 svc saved got write", sav_rd_data, 32'h0000_5151);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_modes();
    t_exc_banks();
    t_fiq();
    t_usr_sys();
    t_saved();
    t_status();
    t_invalid();
    t_same();
    t_order();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule